// File: doc/BRIEF.md
# Receive Descriptor Poll Controller

This block decides when the receive side of a DMA buffer-management engine fetches its next descriptor. A down-counter restarts after every fetch and raises a fetch when it runs out. The host can also force a fetch at once by writing a demand flag. It can switch timer polling off, so that fetches then happen only on demand.

The controller sends a request to the DMA engine and holds it until the engine reports that the fetch is done. Only one request is outstanding at a time. A demand that arrives while a fetch is under way is served by that fetch. No new fetch starts while the receiver is disabled.

A hard reset clears both host flags. A soft reset or a stop leaves both flags as they are, but drops any pending request and restarts the poll counter. The work of the fetch itself and the ring addressing belong to the DMA engine.

Top module: `rx_desc_poll_ctrl`

## Requirements
- R1: While `hard_rst` is high, and on the first cycle after it falls, `fetch_req`, `demand_flag` and `poll_off_flag` are all 0.
- R2: With `rx_en`=1 and `poll_off_flag`=0, `fetch_req` rises PERIOD cycles after the hard reset is released, and again PERIOD cycles after each cycle in which `fetch_done` completes a fetch.
- R3: A host write (`host_wr`=1) with `host_demand`=1 sets `demand_flag` on the next edge. `fetch_req` rises on the edge after that, whatever the count in the poll counter.
- R4: A host write with `host_demand`=0 leaves `demand_flag` unchanged.
- R5: `demand_flag` clears on the edge where `fetch_done`=1 ends an outstanding fetch.
- R6: Every host write loads `host_poll_off` into `poll_off_flag`. While `poll_off_flag`=1, no timer fetch is issued, and a fetch starts only when `demand_flag`=1.
- R7: While `rx_en`=0, no new fetch starts and a pending demand stays set. A fetch starts on the first edge after `rx_en` returns to 1.
- R8: `fetch_req` stays high until `fetch_done`=1. A `fetch_done` pulse while no request is outstanding has no effect on `fetch_req` or `demand_flag`.
- R9: A demand written while a fetch is outstanding causes no second fetch. It is cleared when that fetch completes.
- R10: A `soft_rst` or `stop_req` pulse leaves `demand_flag` and `poll_off_flag` unchanged, drops `fetch_req` on the next edge and restarts the poll counter, so the next timer fetch comes PERIOD cycles later.
- R11: The poll counter restarts after every fetch, including fetches started by a demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous active-high hard reset; clears all state |
| soft_rst | input | 1 | Soft reset; keeps the host flags, cancels the request, restarts the counter |
| stop_req | input | 1 | Stop; same effect on this block as a soft reset |
| rx_en | input | 1 | Receiver enable; no fetch starts while it is 0 |
| host_wr | input | 1 | Host register write strobe |
| host_demand | input | 1 | Write data for the demand flag (a 1 sets it, a 0 does nothing) |
| host_poll_off | input | 1 | Write data for the poll-disable flag |
| fetch_done | input | 1 | DMA engine reports that the descriptor fetch is complete |
| fetch_req | output | 1 | Registered request for a descriptor fetch |
| demand_flag | output | 1 | Current state of the demand flag |
| poll_off_flag | output | 1 | Current state of the poll-disable flag |

## Verification
On every cycle, the assertions check the following:
- the request is held until `fetch_done` arrives;
- a request never starts while the receiver is off;
- a request never starts from the timer while polling is off;
- the demand flag reacts correctly to write-one, write-zero and completion;
- the counter restart clears the expiry.

Some properties can only be shown by the directed scenarios:
- the exact PERIOD-cycle spacing of timer fetches;
- that a soft reset or stop preserves the flags while restarting the counter;
- that a demand written during a fetch is absorbed;
- that a stray `fetch_done` is ignored.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fetch_state_t;
endpackage

// File: rtl/rdp_host_regs.sv
module rdp_host_regs (
  input  logic clk,
  input  logic hard_rst,
  input  logic host_wr,
  input  logic host_demand,
  input  logic host_poll_off,
  input  logic fetch_clr,
  output logic demand_q,
  output logic poll_off_q
);

  // Demand: write-one-to-set; completion of a fetch wins over a same-cycle set
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      demand_q <= 1'b0;
    end else if (fetch_clr) begin
      demand_q <= 1'b0;
    end else if (host_wr && host_demand) begin
      demand_q <= 1'b1;
    end
  end

  // Poll-disable: plain read/write flag, cleared only by hard reset
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      poll_off_q <= 1'b0;
    end else if (host_wr) begin
      poll_off_q <= host_poll_off;
    end
  end

  // R3
  dem_set_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (host_wr && host_demand && !fetch_clr) |=> demand_q);

  // R4
  dem_zero_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (host_wr && !host_demand && !fetch_clr) |=> (demand_q == $past(demand_q)));

  // R5
  dem_clr_chk: assert property (@(posedge clk) disable iff (hard_rst)
    fetch_clr |=> !demand_q);

endmodule

// File: rtl/rdp_poll_timer.sv
module rdp_poll_timer #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic restart,
  input  logic run,
  output logic expired
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q <= RELOAD;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R11
  generate
    if (PERIOD > 1) begin : g_restart_chk
      restart_clears_chk: assert property (@(posedge clk)
        restart |=> !expired);
    end
  endgenerate

endmodule

// File: rtl/rdp_fetch_arb.sv
module rdp_fetch_arb
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic hard_rst,
  input  logic abort,
  input  logic rx_en,
  input  logic demand,
  input  logic poll_off,
  input  logic expired,
  input  logic fetch_done,
  output logic issue,
  output logic fetch_clr,
  output logic fetch_req
);

  fetch_state_t state_q;

  logic want;
  assign want  = demand || (!poll_off && expired);
  assign issue = (state_q == FS_IDLE) && rx_en && want && !abort && !hard_rst;
  assign fetch_clr = (state_q == FS_BUSY) && fetch_done;

  always_ff @(posedge clk) begin
    if (hard_rst || abort) begin
      state_q <= FS_IDLE;
    end else begin
      case (state_q)
        FS_IDLE: if (issue)      state_q <= FS_BUSY;
        FS_BUSY: if (fetch_done) state_q <= FS_IDLE;
        default:                 state_q <= FS_IDLE;
      endcase
    end
  end

  assign fetch_req = (state_q == FS_BUSY);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (fetch_req && !fetch_done && !abort) |=> fetch_req);

  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(fetch_req) |-> $past(rx_en));

  // R6
  poll_off_chk: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(fetch_req) |-> $past(demand || !poll_off));

endmodule

// File: rtl/rx_desc_poll_ctrl.sv
module rx_desc_poll_ctrl #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic soft_rst,
  input  logic stop_req,
  input  logic rx_en,
  input  logic host_wr,
  input  logic host_demand,
  input  logic host_poll_off,
  input  logic fetch_done,
  output logic fetch_req,
  output logic demand_flag,
  output logic poll_off_flag
);

  logic abort;
  logic issue;
  logic fetch_clr;
  logic expired;
  logic timer_restart;
  logic timer_run;

  assign abort = soft_rst || stop_req;

  rdp_host_regs u_regs (
    .clk          (clk),
    .hard_rst     (hard_rst),
    .host_wr      (host_wr),
    .host_demand  (host_demand),
    .host_poll_off(host_poll_off),
    .fetch_clr    (fetch_clr),
    .demand_q     (demand_flag),
    .poll_off_q   (poll_off_flag)
  );

  assign timer_restart = hard_rst || abort || issue || !rx_en || poll_off_flag;
  assign timer_run     = !fetch_req;

  rdp_poll_timer #(.PERIOD(PERIOD)) u_timer (
    .clk    (clk),
    .restart(timer_restart),
    .run    (timer_run),
    .expired(expired)
  );

  rdp_fetch_arb u_arb (
    .clk       (clk),
    .hard_rst  (hard_rst),
    .abort     (abort),
    .rx_en     (rx_en),
    .demand    (demand_flag),
    .poll_off  (poll_off_flag),
    .expired   (expired),
    .fetch_done(fetch_done),
    .issue     (issue),
    .fetch_clr (fetch_clr),
    .fetch_req (fetch_req)
  );

  // R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (hard_rst)
    abort |=> !fetch_req);

endmodule

// File: tb/sim_rx_desc_poll_ctrl.sv
module sim_rx_desc_poll_ctrl;
  localparam int P = 16;

  logic clk = 1'b0;
  logic hard_rst = 1'b1, soft_rst = 1'b0, stop_req = 1'b0, rx_en = 1'b0;
  logic host_wr = 1'b0, host_demand = 1'b0, host_poll_off = 1'b0, fetch_done = 1'b0;
  logic fetch_req, demand_flag, poll_off_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_desc_poll_ctrl #(.PERIOD(P)) u0 (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .stop_req(stop_req),
    .rx_en(rx_en), .host_wr(host_wr), .host_demand(host_demand),
    .host_poll_off(host_poll_off), .fetch_done(fetch_done),
    .fetch_req(fetch_req), .demand_flag(demand_flag), .poll_off_flag(poll_off_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    hard_rst = 1'b1; soft_rst = 1'b0; stop_req = 1'b0; host_wr = 1'b0; fetch_done = 1'b0;
    repeat (3) @(negedge clk);
    hard_rst = 1'b0;
  endtask

  task automatic host_write(input logic dem, input logic poff);
    host_wr = 1'b1; host_demand = dem; host_poll_off = poff;
    @(negedge clk);
    host_wr = 1'b0; host_demand = 1'b0;
  endtask

  task automatic wait_req(output int n, input int limit);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (fetch_req) break;
    end
    if (!fetch_req) n = -1;
  endtask

  task automatic complete();
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rx_en = 1'b1;
    @(negedge clk);
    host_write(1'b1, 1'b1);
    hard_rst = 1'b1;
    @(negedge clk);
    check("R1 req in reset", fetch_req, 0);
    check("R1 demand in reset", demand_flag, 0);
    check("R1 poll_off in reset", poll_off_flag, 0);
    hard_rst = 1'b0;
    wait_req(n, 4 * P);
    check("R2 first timer fetch gap", n, P);
    complete();
  endtask

  task automatic t_auto();
    int n;
    wait_req(n, 4 * P);
    check("R2 timer fetch gap after done", n, P);
    repeat (5) @(negedge clk);
    check("R8 request held without done", fetch_req, 1);
    complete();
    check("R8 request drops on done", fetch_req, 0);
  endtask

  task automatic t_demand();
    int n;
    repeat (3) @(negedge clk);
    host_write(1'b1, 1'b0);
    check("R3 demand flag set", demand_flag, 1);
    check("R3 no request yet", fetch_req, 0);
    @(negedge clk);
    check("R3 request after demand", fetch_req, 1);
    complete();
    check("R5 demand cleared on done", demand_flag, 0);
    wait_req(n, 4 * P);
    check("R11 counter restarted by demand fetch", n, P);
    complete();
  endtask

  task automatic t_write_zero();
    host_write(1'b0, 1'b1);
    check("R4 zero write keeps demand clear", demand_flag, 0);
    check("R6 poll_off loaded", poll_off_flag, 1);
    rx_en = 1'b0;
    host_write(1'b1, 1'b1);
    host_write(1'b0, 1'b1);
    check("R4 zero write keeps demand set", demand_flag, 1);
  endtask

  task automatic t_rx_off();
    repeat (3 * P) @(negedge clk);
    check("R7 no fetch while rx off", fetch_req, 0);
    check("R7 demand stays pending", demand_flag, 1);
    complete();
    check("R8 stray done keeps demand", demand_flag, 1);
    check("R8 stray done keeps req low", fetch_req, 0);
    rx_en = 1'b1;
    @(negedge clk);
    check("R7 fetch when rx returns", fetch_req, 1);
    complete();
  endtask

  task automatic t_poll_off();
    int n;
    wait_req(n, 3 * P);
    check("R6 no timer fetch when polling off", n, -1);
    host_write(1'b1, 1'b1);
    @(negedge clk);
    check("R6 demand fetch with polling off", fetch_req, 1);
    host_write(1'b1, 1'b1);
    check("R9 demand during fetch pending", demand_flag, 1);
    complete();
    check("R9 absorbed demand cleared", demand_flag, 0);
    wait_req(n, 3 * P);
    check("R9 no second fetch", n, -1);
  endtask

  task automatic t_soft();
    int n;
    host_write(1'b1, 1'b1);
    @(negedge clk);
    check("R10 fetch before soft reset", fetch_req, 1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R10 soft reset drops request", fetch_req, 0);
    check("R10 soft reset keeps poll_off", poll_off_flag, 1);
    check("R10 soft reset keeps demand", demand_flag, 1);
    @(negedge clk);
    check("R10 refetch of kept demand", fetch_req, 1);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R10 stop drops request", fetch_req, 0);
    check("R10 stop keeps demand", demand_flag, 1);
    @(negedge clk);
    complete();
    host_write(1'b0, 1'b0);
    repeat (P / 2) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    wait_req(n, 4 * P);
    check("R10 counter restarted by stop", n, P);
    complete();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_auto();
    t_demand();
    t_write_zero();
    t_rx_off();
    t_poll_off();
    t_soft();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule